// File: doc/BRIEF.md
# Timebase Interval Timer with Overflow Flag

This block is a free-running prescaler that counts every cycle of the main clock. It raises an overflow flag each time a selected counter bit carries, which marks the end of one interval. Software reaches a single 16-bit control word through a small register bus. In that word it picks one of four interval lengths, enables the interrupt request, acknowledges the flag and restarts the count.

Both the flag and the counter restart are cleared by writing 0. Writing 1 leaves them unchanged, so a plain write can update the interval select or the enable bit without side effects. A read-modify-write qualifier makes the flag read as 1, so writing back the value just read never acknowledges an overflow by accident. A single-cycle clear-request input stands for clock-mode changes in the surrounding system. It drops the flag and leaves the count running.

Top module: `tbt_interval_timer`

## Requirements
- R1: Interval select code (word bits 9:8) maps 00→2^12, 01→2^14, 10→2^16, 11→2^19 clock cycles per interval; the code is 00 after reset.
- R2: After the counter is restarted, the flag (word bit 11) first reads 1 exactly 2^N clock edges later, where 2^N is the selected interval length, and it stays 1 until cleared.
- R3: A write with bit 10 at 0 restarts the counter from zero and clears the flag; a write with bit 10 at 1 leaves the count untouched.
- R4: Bit 10 of the word always reads 1.
- R5: A write with bit 11 at 0 clears the flag; a write with bit 11 at 1 leaves it as it was.
- R6: A read with the read-modify-write qualifier high returns bit 11 as 1 whatever the flag holds.
- R7: The interrupt request is 1 exactly when the flag and the enable bit (word bit 12) are both 1, and it changes on the same clock edge as the flag. With the enable bit at 0 the flag still sets.
- R8: A one-cycle pulse on the mode-change clear input clears the flag on the next edge and leaves the counter running.
- R9: An interval end in the same cycle as any flag clear wins: the flag is 1 after that edge.
- R10: After reset the word reads 0x8400: the reserved bit 15 reads 1, bit 10 reads 1, and every other bit reads 0. Bits 14:13 and 7:0 ignore writes and always read 0.
- R11: Read data is registered. It holds the word one clock edge after the matching address is presented and holds 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write enable for the addressed word |
| bus_rmw | input | 1 | Read-modify-write qualifier for reads |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| mode_clr | input | 1 | One-cycle clear request from a clock-mode change |
| irq | output | 1 | Registered interrupt request |

## Verification
A counter that drifts or restarts at the wrong moment shows up on the interrupt request, which the bench samples on the exact edge where the interval should end and on the edge before it. An off-by-one in the carry detect is therefore caught within one interval. A flag whose clear priority is wrong, or a counter that a flag clear resets by mistake, moves the next request by a whole interval or suppresses it, and the bench detects this at the following boundary. Field and read-modify-write faults appear in the read word one edge after the read is issued.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int REG_W   = 16;
  localparam int SEL_W   = 2;
  localparam int N_TAP   = 2 ** SEL_W;
  localparam int SEL_LO  = 8;
  localparam int CLR_BIT = 10;
  localparam int FLG_BIT = 11;
  localparam int IE_BIT  = 12;
  localparam int RSV_BIT = 15;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic ie;
    logic flag;
    sel_t sel;
  } ctrl_state_t;

  function automatic int max_exp(input int e0, input int e1, input int e2, input int e3);
    int m;
    m = e0;
    if (e1 > m) m = e1;
    if (e2 > m) m = e2;
    if (e3 > m) m = e3;
    return m;
  endfunction
endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  assert_free_run_R8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/tbt_tap_sel.sv
module tbt_tap_sel
  import tbt_pkg::*;
#(
  parameter int CNT_W = 19,
  parameter int EXP0  = 12,
  parameter int EXP1  = 14,
  parameter int EXP2  = 16,
  parameter int EXP3  = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  sel_t             sel,
  output logic             tick
);
  localparam int EXPS [N_TAP] = '{EXP0, EXP1, EXP2, EXP3};

  logic [N_TAP-1:0] tick_vec;

  for (genvar i = 0; i < N_TAP; i++) begin : g_tap
    assign tick_vec[i] = &cnt[EXPS[i]-1:0];
    if (i > 0) begin : g_nest
      assert_tap_nested_R1: assert property (@(posedge clk) disable iff (rst)
        tick_vec[i] |-> tick_vec[i-1]);
    end
  end

  assign tick = tick_vec[sel];
endmodule

// File: rtl/tbt_ctrl.sv
module tbt_ctrl
  import tbt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rmw,
  input  logic              wr_ie,
  input  logic              wr_flag,
  input  logic              wr_run,
  input  sel_t              wr_sel,
  input  logic              mode_clr,
  input  logic              tick,
  output sel_t              sel,
  output logic              cnt_clr,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  ctrl_state_t st, st_nxt;
  logic hit, wr_hit, flag_drop;
  logic [REG_W-1:0] rd_word;

  assign hit       = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign wr_hit    = hit && bus_wr;
  assign cnt_clr   = wr_hit && !wr_run;
  assign flag_drop = mode_clr || (wr_hit && (!wr_flag || !wr_run));
  assign sel       = st.sel;

  always_comb begin
    st_nxt = st;
    if (wr_hit) begin
      st_nxt.ie  = wr_ie;
      st_nxt.sel = wr_sel;
    end
    if (tick)           st_nxt.flag = 1'b1;
    else if (flag_drop) st_nxt.flag = 1'b0;
  end

  always_comb begin
    rd_word = '0;
    if (hit) begin
      rd_word[RSV_BIT]               = 1'b1;
      rd_word[IE_BIT]                = st.ie;
      rd_word[FLG_BIT]               = st.flag || bus_rmw;
      rd_word[CLR_BIT]               = 1'b1;
      rd_word[SEL_LO +: SEL_W]       = st.sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      st        <= st_nxt;
      irq       <= st_nxt.flag && st_nxt.ie;
      bus_rdata <= rd_word;
    end
  end

  assert_flag_sets_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> st.flag);

  assert_flag_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wr_flag && !tick) |=> !st.flag);

  assert_mode_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_clr && !tick) |=> !st.flag);

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (st.flag && !flag_drop) |=> st.flag);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (st.flag && st.ie));

  assert_clr_reads_one_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> bus_rdata[CLR_BIT]);
endmodule

// File: rtl/tbt_interval_timer.sv
module tbt_interval_timer
  import tbt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 3,
  parameter int EXP0      = 12,
  parameter int EXP1      = 14,
  parameter int EXP2      = 16,
  parameter int EXP3      = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rmw,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              mode_clr,
  output logic              irq
);
  localparam int CNT_W = max_exp(EXP0, EXP1, EXP2, EXP3);

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, tick;
  sel_t             sel;
  logic             wdata_unused;

  assign wdata_unused = ^{bus_wdata[REG_W-1:IE_BIT+1], bus_wdata[SEL_LO-1:0]};

  tbt_prescaler #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .cnt (cnt)
  );

  tbt_tap_sel #(
    .CNT_W(CNT_W), .EXP0(EXP0), .EXP1(EXP1), .EXP2(EXP2), .EXP3(EXP3)
  ) u_tap (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt),
    .sel  (sel),
    .tick (tick)
  );

  tbt_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rmw   (bus_rmw),
    .wr_ie     (bus_wdata[IE_BIT]),
    .wr_flag   (bus_wdata[FLG_BIT]),
    .wr_run    (bus_wdata[CLR_BIT]),
    .wr_sel    (bus_wdata[SEL_LO +: SEL_W]),
    .mode_clr  (mode_clr),
    .tick      (tick),
    .sel       (sel),
    .cnt_clr   (cnt_clr),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );
endmodule

// File: tb/sim_tbt_interval_timer.sv
module sim_tbt_interval_timer;
  localparam int AW = 4;
  localparam logic [AW-1:0] CA = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rmw = 1'b0, mode_clr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic mon_arm = 1'b0;

  always #2.5 clk = ~clk;

  tbt_interval_timer #(.ADDR_W(AW), .CTRL_ADDR(3)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rmw(bus_rmw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_clr(mode_clr), .irq(irq)
  );

  // monitor: pops expected read words as the design registers them
  always @(posedge clk) begin
    if (mon_arm) begin
      #1;
      if (exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  function automatic logic [15:0] mk(input logic ie, input logic fk,
                                     input logic ck, input logic [1:0] s);
    return 16'h8000 | (16'(ie) << 12) | (16'(fk) << 11) | (16'(ck) << 10) | (16'(s) << 8);
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    bus_addr = CA; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic rmw,
                    input logic [15:0] e, input string t);
    bus_addr = a; bus_rmw = rmw;
    exp_q.push_back(e); tag_q.push_back(t);
    mon_arm = 1'b1;
    @(negedge clk);
    mon_arm = 1'b0; bus_rmw = 1'b0;
  endtask

  task automatic mclr();
    mode_clr = 1'b1;
    @(negedge clk);
    mode_clr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    // R10 reset state, R11 address decode
    rd(CA, 1'b0, 16'h8400, "R10 reset word");
    rd(4'h5, 1'b0, 16'h0000, "R11 other address");
    chk_irq(1'b0, "R10 reset irq");

    // R1/R2/R7 shortest interval
    wr(mk(1, 1, 0, 2'd0));
    step(4095); chk_irq(1'b0, "R1 before 2^12");
    step(1);    chk_irq(1'b1, "R2 R7 at 2^12");
    rd(CA, 1'b0, 16'h9C00, "R2 flag read");
    rd(CA, 1'b1, 16'h9C00, "R6 rmw flag set");
    wr(mk(1, 1, 1, 2'd0)); chk_irq(1'b1, "R5 write 1 keeps flag");
    wr(mk(1, 0, 1, 2'd0)); chk_irq(1'b0, "R5 write 0 clears flag");
    rd(CA, 1'b0, 16'h9400, "R4 R5 word after ack");
    rd(CA, 1'b1, 16'h9C00, "R6 rmw flag clear");
    wr(16'hFCFF);
    rd(CA, 1'b0, 16'h9400, "R10 unused bits");

    // R7 flag without enable, R8 mode clear
    wr(mk(0, 1, 0, 2'd0));
    step(4096); chk_irq(1'b0, "R7 enable off");
    rd(CA, 1'b0, 16'h8C00, "R7 flag set enable off");
    mclr();
    rd(CA, 1'b0, 16'h8400, "R8 mode clear flag");

    // R8 counter keeps running across mode clear
    wr(mk(1, 1, 0, 2'd0));
    step(4096); chk_irq(1'b1, "R8 first interval");
    mclr();     chk_irq(1'b0, "R8 cleared");
    step(4094); chk_irq(1'b0, "R8 before second end");
    step(1);    chk_irq(1'b1, "R8 counter not restarted");

    // R3 restart clears flag, write 1 no effect
    wr(mk(1, 1, 0, 2'd0)); chk_irq(1'b0, "R3 restart clears flag");
    step(2000);
    wr(mk(1, 1, 1, 2'd0));
    step(2094); chk_irq(1'b0, "R3 write 1 no restart, before");
    step(1);    chk_irq(1'b1, "R3 write 1 no restart, at end");

    // R9 interval end beats same-cycle clear
    wr(mk(1, 0, 0, 2'd0)); chk_irq(1'b0, "R9 setup");
    step(4095);
    wr(mk(1, 0, 1, 2'd0)); chk_irq(1'b1, "R9 tick beats write 0");
    wr(mk(1, 0, 1, 2'd0)); chk_irq(1'b0, "R9 ack");
    step(4094);
    mclr();     chk_irq(1'b1, "R9 tick beats mode clear");

    // R1 other select codes
    wr(mk(1, 1, 0, 2'd1));
    rd(CA, 1'b0, 16'h9500, "R1 select 01 word");
    step(16382); chk_irq(1'b0, "R1 before 2^14");
    step(1);     chk_irq(1'b1, "R1 at 2^14");
    wr(mk(1, 1, 0, 2'd2));
    step(65535); chk_irq(1'b0, "R1 before 2^16");
    step(1);     chk_irq(1'b1, "R1 at 2^16");
    wr(mk(1, 1, 0, 2'd3));
    step(65536); chk_irq(1'b0, "R1 select 11 beyond 2^16");

    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule